// File: doc/BRIEF.md
# Fully Associative Byte Read Cache with LRU Replacement

This block is a small read-only cache that sits between a requester and a slower byte-wide memory. It holds a few one-byte blocks. Any address may live in any entry: there is no index field, so the full address is kept as the tag and every entry's tag is compared with the incoming address in the same cycle. A match on any valid entry is a hit and is answered from local storage without touching memory.

On a miss the block issues a fetch on its memory port and waits for the acknowledge. The returned byte is written into a free entry if one exists (lowest entry number first). Otherwise it overwrites the entry whose last use is oldest. In the same clock edge that installs the byte, the byte is presented to the requester. Recency is kept as a per-entry age that forms a permutation of 0 to WAYS-1. Age 0 marks the most recently used entry and WAYS-1 the oldest.

The requester raises `cpu_req` with `cpu_addr` and holds both until it sees the one-cycle `cpu_ready` pulse. It then drops the request in that same cycle. The memory side holds `mem_req` and `mem_addr` until `mem_ack` returns with `mem_rdata`.

Top module: `assoc_read_cache`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low and no entry is valid, so the first access to any address misses.
- R2: A request accepted while idle whose address equals a valid stored tag gives `cpu_ready` high with the stored byte on `cpu_rdata` in the next cycle, and `mem_req` is never raised for it.
- R3: A request that matches no valid tag raises `mem_req` in the next cycle with `mem_addr` equal to the request address. Both stay unchanged until the cycle in which `mem_ack` is high.
- R4: In the cycle after `mem_req` and `mem_ack` are both high, `mem_req` is low, `cpu_ready` is high and `cpu_rdata` equals the `mem_rdata` sampled with the acknowledge. The byte is then resident, so the next access to that address hits.
- R5: While an entry is still free, a miss fills that entry and evicts nothing: WAYS distinct addresses read after reset all hit on a second pass.
- R6: When every entry is valid, a miss replaces the entry whose most recent hit or fill lies furthest in the past.
- R7: Accesses that alternate between addresses 2 and 6 miss only on the first access to each and hit on every later one.
- R8: The whole ADDR_W-bit address is the tag: two addresses that differ only in their upper bits are separate blocks and return their own bytes.
- R9: `cpu_ready` is high for exactly one cycle per request, is never high together with `mem_req`, and `cpu_req` is ignored in the cycle `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address of the read |
| cpu_ready | output | 1 | One-cycle pulse: `cpu_rdata` is valid |
| cpu_rdata | output | DATA_W | Byte returned to the requester |
| mem_req | output | 1 | Fetch request to memory, held until `mem_ack` |
| mem_addr | output | ADDR_W | Address of the fetched byte |
| mem_ack | input | 1 | Memory has placed the byte on `mem_rdata` |
| mem_rdata | input | DATA_W | Byte returned by memory |

## Verification
The bench builds the block with its defaults: four entries, 16-bit addresses and 8-bit data. With four entries the free-slot phase, the first eviction and steady LRU churn all occur within a handful of accesses. The 16-bit tag makes it possible to probe addresses that share their low byte and differ only in the upper byte. A behavioural model keyed on last-use timestamps predicts hit or miss for every access, including a long pseudo-random run over eight addresses with memory delays of zero to three cycles.

// File: rtl/ac_pkg.sv
package ac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } ac_state_e;
endpackage

// File: rtl/ac_tag_cam.sv
module ac_tag_cam #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  output logic [WAYS-1:0]  match_vec,
  output logic [WAYS-1:0]  valid_vec,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAYS-1:0]  vld_q;

  for (genvar g = 0; g < WAYS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_tag;
      end
    end
    assign match_vec[g] = vld_q[g] && (tag_q[g] == look_tag);
  end

  assign valid_vec = vld_q;

  // R8: a full-width tag can never be held twice, so at most one entry matches
  a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
endmodule

// File: rtl/ac_age_lru.sv
module ac_age_lru #(
  parameter int WAYS = 4,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAYS-1:0]  valid_vec,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age_q [WAYS];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar g = 0; g < WAYS; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch) begin
        if (touch_idx == IDX_W'(g))
          age_q[g] <= '0;
        else if (age_q[g] < touched_age)
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  // Free entries first, lowest number wins; otherwise the oldest age.
  always_comb begin
    logic found;
    victim_idx = '0;
    found      = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_vec[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == IDX_W'(WAYS - 1)) victim_idx = IDX_W'(i);
      end
    end
  end

  // R6: ages stay a permutation, so exactly one entry holds each age value
  for (genvar v = 0; v < WAYS; v++) begin : g_perm
    logic [WAYS-1:0] holds_v;
    for (genvar e = 0; e < WAYS; e++) begin : g_cmp
      assign holds_v[e] = (age_q[e] == IDX_W'(v));
    end
    a_r6_age_unique: assert property (@(posedge clk) disable iff (rst)
      $countones(holds_v) == 1);
  end

  // R6: a used entry becomes the youngest
  a_r6_touch_young: assert property (@(posedge clk) disable iff (rst)
    touch |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/ac_data_store.sv
module ac_data_store #(
  parameter int WAYS   = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  // Single write port, asynchronous read: maps to distributed RAM.
  logic [DATA_W-1:0] mem_q [WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/assoc_read_cache.sv
module assoc_read_cache #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import ac_pkg::*;

  ac_state_e         state_q;
  logic [WAYS-1:0]   match_vec;
  logic [WAYS-1:0]   valid_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic [IDX_W-1:0]  fill_idx_q;
  logic [DATA_W-1:0] hit_data;
  logic              accept_hit;
  logic              fill_now;
  logic              touch;
  logic [IDX_W-1:0]  touch_idx;

  ac_tag_cam #(.WAYS(WAYS), .TAG_W(ADDR_W)) u_cam (
    .clk       (clk),
    .rst       (rst),
    .look_tag  (cpu_addr),
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .wr_en     (fill_now),
    .wr_idx    (fill_idx_q),
    .wr_tag    (mem_addr)
  );

  ac_age_lru #(.WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch      (touch),
    .touch_idx  (touch_idx),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx)
  );

  ac_data_store #(.WAYS(WAYS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (fill_now),
    .wr_idx  (fill_idx_q),
    .wr_data (mem_rdata),
    .rd_idx  (hit_idx),
    .rd_data (hit_data)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit    = |match_vec;
  assign accept_hit = (state_q == ST_IDLE) && cpu_req && any_hit;
  assign fill_now   = (state_q == ST_FETCH) && mem_ack;
  assign touch      = accept_hit || fill_now;
  assign touch_idx  = fill_now ? fill_idx_q : hit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      fill_idx_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cpu_ready <= 1'b0;
          if (cpu_req) begin
            if (any_hit) begin
              cpu_rdata <= hit_data;
              cpu_ready <= 1'b1;
              state_q   <= ST_RESP;
            end else begin
              mem_req    <= 1'b1;
              mem_addr   <= cpu_addr;
              fill_idx_q <= victim_idx;
              state_q    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= mem_rdata;
            state_q   <= ST_RESP;
          end
        end
        default: begin
          cpu_ready <= 1'b0;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready && mem_req));

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r4_fill_forward: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (cpu_ready && !mem_req && cpu_rdata == $past(mem_rdata)));

  a_r2_hit_no_fetch: assert property (@(posedge clk) disable iff (rst)
    accept_hit |=> (cpu_ready && !mem_req));

  a_r3_miss_fetch: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && cpu_req && !any_hit) |=> (mem_req && mem_addr == $past(cpu_addr)));
endmodule

// File: tb/sim_assoc_read_cache.sv
module sim_assoc_read_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cycle_cnt = 0;
  bit finished = 0;

  // reference model: tags, valid flags, last-use timestamps
  logic [15:0] m_tag [NW];
  bit          m_vld [NW];
  int          m_use [NW];
  int          m_time = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_read_cache u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycle_cnt++;
    if (cycle_cnt > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle_cnt, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_read(input logic [15:0] a, input int dly, input string req);
    int  hit_slot;
    int  cyc;
    int  waitc;
    bit  saw_mreq;
    bit  done;
    hit_slot = -1;
    for (int i = 0; i < NW; i++) if (m_vld[i] && m_tag[i] == a) hit_slot = i;

    @(negedge clk);
    cpu_req  = 1'b1;
    cpu_addr = a;
    cyc = 0; waitc = 0; saw_mreq = 0; done = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (mem_req) begin
        if (!saw_mreq) begin
          saw_mreq = 1;
          check(mem_addr == a, "R3 fetch address", mem_addr, a);
        end else if (mem_addr != a) begin
          check(0, "R3 address held", mem_addr, a);
        end
        if (waitc == dly) begin
          mem_ack   = 1'b1;
          mem_rdata = mem_byte(a);
        end
        waitc++;
      end
      if (cpu_ready) begin
        mem_ack = 1'b0;
        cpu_req = 1'b0;
        check(saw_mreq == (hit_slot < 0), req, saw_mreq, hit_slot < 0);
        check(cpu_rdata == mem_byte(a), (hit_slot < 0) ? "R4 fill data" : "R2 hit data",
              cpu_rdata, mem_byte(a));
        if (hit_slot >= 0) check(cyc == 1, "R2 hit latency", cyc, 1);
        done = 1;
      end
      if (cyc > 500) begin
        check(0, "no response", cyc, 0);
        cpu_req = 1'b0;
        mem_ack = 1'b0;
        done = 1;
      end
    end
    @(negedge clk);
    check(!cpu_ready, "R9 ready pulse", cpu_ready, 0);

    // update model
    m_time++;
    if (hit_slot >= 0) begin
      m_use[hit_slot] = m_time;
    end else begin
      int v;
      v = -1;
      for (int i = 0; i < NW; i++) if (!m_vld[i] && v < 0) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < NW; i++) if (m_use[i] < m_use[v]) v = i;
      end
      m_vld[v] = 1; m_tag[v] = a; m_use[v] = m_time;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [15:0] pool [8];
    for (int i = 0; i < NW; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_use[i] = 0; end
    pool[0] = 16'h0002; pool[1] = 16'h0006; pool[2] = 16'h0010; pool[3] = 16'h0020;
    pool[4] = 16'h0030; pool[5] = 16'h0102; pool[6] = 16'h0202; pool[7] = 16'hFFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cpu_ready && !mem_req, "R1 reset outputs", {cpu_ready, mem_req}, 0);

    // R1 / R7: alternate 2 and 6
    do_read(16'h0002, 0, "R1 first access misses");
    do_read(16'h0006, 2, "R7 alternate");
    for (int k = 0; k < 6; k++) do_read((k % 2) ? 16'h0006 : 16'h0002, 1, "R7 alternate");

    // R5: fill remaining free entries, then all four hit
    do_read(16'h0010, 3, "R5 free fill");
    do_read(16'h0020, 0, "R5 free fill");
    do_read(16'h0002, 0, "R5 no eviction");
    do_read(16'h0006, 0, "R5 no eviction");
    do_read(16'h0010, 0, "R5 no eviction");
    do_read(16'h0020, 0, "R5 no eviction");

    // R6: use 2, then a new block must evict 6 (oldest)
    do_read(16'h0002, 0, "R6 touch");
    do_read(16'h0030, 1, "R6 new block");
    do_read(16'h0006, 2, "R6 victim was oldest");
    do_read(16'h0002, 0, "R6 recent block kept");

    // R8: only upper address bits differ
    do_read(16'h0102, 1, "R8 full tag");
    do_read(16'h0202, 1, "R8 full tag");
    do_read(16'h0102, 0, "R8 full tag");
    do_read(16'h0202, 0, "R8 full tag");

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_read(pool[lfsr[2:0]], int'(lfsr[5:4]), "R6 random traffic");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule